// File: doc/BRIEF.md
# Graphics Core Interrupt Controller

This block gathers the interrupt sources of a tile-binning graphics engine and presents them to a host processor as one interrupt line. It has three sources. Two are one-cycle completion pulses: a render frame has finished, and the binning flush has finished. Each pulse is latched into a pending bit. The third source is a level condition: the binner has run out of memory. That condition keeps its pending bit asserted until the host supplies a fresh overflow memory pool.

The host reaches the block through a simple register bus. A request lasts one cycle and read data returns on the following cycle. Pending bits are acknowledged by writing ones. The enable mask is changed only through a pair of registers: one sets bits and the other clears them, and both read back the same mask. To service an out-of-memory interrupt, the host writes the pool base and then the pool size, acknowledges the pending bit and re-enables the source. The pool values drive the binner directly.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After reset the pending bits, the enable mask, the pool base, the pool size, the interrupt output and the read data are all zero.
- R2: A pulse on frame_done_i sets pending bit 0. A pulse on flush_done_i sets pending bit 1. Each bit stays set after its pulse has ended.
- R3: A write to offset 0x00 clears every pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R4: A write to offset 0x04 sets every enable bit whose write-data bit is 1. The other enable bits keep their value.
- R5: A write to offset 0x08 clears every enable bit whose write-data bit is 1. The other enable bits keep their value.
- R6: A read returns its data on the cycle after the request. Offset 0x00 returns the pending bits in [2:0]. Offsets 0x04 and 0x08 both return the enable mask in [2:0]. All other data bits read as zero.
- R7: irq_o is high on the cycle after any pending bit and its enable bit are both 1. It is low on the cycle after no such pair exists.
- R8: A pulse on bin_oom_i starts an out-of-memory condition that sets pending bit 2. While the condition lasts, a write to 0x00 does not clear bit 2.
- R9: Offset 0x0C holds the pool base and offset 0x10 holds the pool size. Both are readable and drive pool_base_o and pool_size_o. A write to 0x10 ends the out-of-memory condition, so a later acknowledge clears bit 2.
- R10: When a source event and an acknowledge of the same pending bit fall in the same cycle, the bit remains set.
- R11: Writes to an unmapped offset change no register. Reads from an unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel_i | input | 1 | Bus request valid for one cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 5 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| frame_done_i | input | 1 | Render frame finished pulse |
| flush_done_i | input | 1 | Binning flush finished pulse |
| bin_oom_i | input | 1 | Binner out-of-memory pulse |
| irq_o | output | 1 | Registered interrupt to the host |
| pool_base_o | output | 32 | Overflow pool base address to the binner |
| pool_size_o | output | 32 | Overflow pool size to the binner |

## Verification
The bench checks the clear and enable registers with mixed one and zero patterns. A design that treated zero bits as commands would wipe unrelated bits. It checks that the enable-clear offset reads back the mask, not zero or its complement. It collides an event with an acknowledge of the same bit; a design that gave priority to the write would lose an interrupt. It acknowledges the out-of-memory bit both before and after the pool is reprogrammed. A design that treated that source as a latched event would drop the bit too early, and one that never ended the condition would keep it forever.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
    localparam int unsigned NUM_SRC    = 3;
    localparam int unsigned REG_ADDR_W = 5;
    localparam int unsigned SRC_FRAME  = 0;
    localparam int unsigned SRC_FLUSH  = 1;
    localparam int unsigned SRC_OOM    = 2;

    localparam logic [REG_ADDR_W-1:0] OFS_PEND   = 5'h00;
    localparam logic [REG_ADDR_W-1:0] OFS_EN_SET = 5'h04;
    localparam logic [REG_ADDR_W-1:0] OFS_EN_CLR = 5'h08;
    localparam logic [REG_ADDR_W-1:0] OFS_BASE   = 5'h0C;
    localparam logic [REG_ADDR_W-1:0] OFS_SIZE   = 5'h10;

    typedef struct packed {
        logic ack_pend;
        logic en_set;
        logic en_clr;
        logic base;
        logic size;
    } wr_stb_t;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_PEND,
        RSEL_MASK,
        RSEL_BASE,
        RSEL_SIZE
    } rd_sel_e;
endpackage

// File: rtl/gfx_irq_regdec.sv
module gfx_irq_regdec
    import gfx_irq_pkg::*;
(
    input  logic                  sel_i,
    input  logic                  we_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    output wr_stb_t               wstb_o,
    output rd_sel_e               rsel_o
);
    always_comb begin
        wstb_o = '0;
        rsel_o = RSEL_NONE;
        if (sel_i) begin
            unique case (addr_i)
                OFS_PEND: begin
                    wstb_o.ack_pend = we_i;
                    rsel_o          = RSEL_PEND;
                end
                OFS_EN_SET: begin
                    wstb_o.en_set = we_i;
                    rsel_o        = RSEL_MASK;
                end
                OFS_EN_CLR: begin
                    wstb_o.en_clr = we_i;
                    rsel_o        = RSEL_MASK;
                end
                OFS_BASE: begin
                    wstb_o.base = we_i;
                    rsel_o      = RSEL_BASE;
                end
                OFS_SIZE: begin
                    wstb_o.size = we_i;
                    rsel_o      = RSEL_SIZE;
                end
                default: ;
            endcase
            if (we_i) rsel_o = RSEL_NONE;
        end
    end
endmodule

// File: rtl/gfx_irq_core.sv
module gfx_irq_core
    import gfx_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_evt_i,
    input  logic               flush_evt_i,
    input  logic               oom_evt_i,
    input  wr_stb_t            wstb_i,
    input  logic [NUM_SRC-1:0] wbits_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] mask;
        logic               oom_cond;
        logic               irq;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [NUM_SRC-1:0] hw_set;
    logic [NUM_SRC-1:0] ack_bits;

    always_comb begin
        hw_set            = '0;
        hw_set[SRC_FRAME] = frame_evt_i;
        hw_set[SRC_FLUSH] = flush_evt_i;
        hw_set[SRC_OOM]   = oom_evt_i | st_q.oom_cond;
        ack_bits          = wstb_i.ack_pend ? wbits_i : '0;

        st_d          = st_q;
        st_d.pend     = hw_set | (st_q.pend & ~ack_bits);
        if (wstb_i.en_set) st_d.mask = st_q.mask | wbits_i;
        if (wstb_i.en_clr) st_d.mask = st_q.mask & ~wbits_i;
        st_d.oom_cond = oom_evt_i | (st_q.oom_cond & ~wstb_i.size);
        st_d.irq      = |(st_q.pend & st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;
    assign irq_o  = st_q.irq;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit_chk
        a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[k] |=> st_q.pend[k]);
        a_r4_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
            (wstb_i.en_set && wbits_i[k]) |=> st_q.mask[k]);
        a_r5_clr_bit: assert property (@(posedge clk) disable iff (!rst_n)
            (wstb_i.en_clr && wbits_i[k]) |=> !st_q.mask[k]);
        a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (wstb_i.ack_pend && wbits_i[k] && !hw_set[k]) |=> !st_q.pend[k]);
    end

    a_r8_oom_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.oom_cond |=> st_q.pend[SRC_OOM]);
    a_r7_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(st_q.pend & st_q.mask)) |=> !st_q.irq);
    a_r7_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_q.pend & st_q.mask)) |=> st_q.irq);
endmodule

// File: rtl/gfx_irq_pool.sv
module gfx_irq_pool #(
    parameter int unsigned BASE_W = 32,
    parameter int unsigned SIZE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr_i,
    input  logic              size_wr_i,
    input  logic [BASE_W-1:0] base_wdata_i,
    input  logic [SIZE_W-1:0] size_wdata_i,
    output logic [BASE_W-1:0] base_o,
    output logic [SIZE_W-1:0] size_o
);
    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [SIZE_W-1:0] size;
    } pool_st_t;

    pool_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (base_wr_i) st_d.base = base_wdata_i;
        if (size_wr_i) st_d.size = size_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_o = st_q.base;
    assign size_o = st_q.size;

    a_r9_size_load: assert property (@(posedge clk) disable iff (!rst_n)
        size_wr_i |=> (st_q.size == $past(size_wdata_i)));
    a_r9_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !base_wr_i |=> $stable(st_q.base));
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
    import gfx_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BASE_W = 32,
    parameter int unsigned SIZE_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_sel_i,
    input  logic                  reg_we_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    input  logic                  frame_done_i,
    input  logic                  flush_done_i,
    input  logic                  bin_oom_i,
    output logic                  irq_o,
    output logic [BASE_W-1:0]     pool_base_o,
    output logic [SIZE_W-1:0]     pool_size_o
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_st_t;

    wr_stb_t            wstb;
    rd_sel_e            rsel;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] mask;
    rd_st_t             rd_d, rd_q;

    gfx_irq_regdec u_dec (
        .sel_i  (reg_sel_i),
        .we_i   (reg_we_i),
        .addr_i (reg_addr_i),
        .wstb_o (wstb),
        .rsel_o (rsel)
    );

    gfx_irq_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_evt_i (frame_done_i),
        .flush_evt_i (flush_done_i),
        .oom_evt_i   (bin_oom_i),
        .wstb_i      (wstb),
        .wbits_i     (reg_wdata_i[NUM_SRC-1:0]),
        .pend_o      (pend),
        .mask_o      (mask),
        .irq_o       (irq_o)
    );

    gfx_irq_pool #(.BASE_W(BASE_W), .SIZE_W(SIZE_W)) u_pool (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_wr_i    (wstb.base),
        .size_wr_i    (wstb.size),
        .base_wdata_i (reg_wdata_i[BASE_W-1:0]),
        .size_wdata_i (reg_wdata_i[SIZE_W-1:0]),
        .base_o       (pool_base_o),
        .size_o       (pool_size_o)
    );

    always_comb begin
        rd_d.rdata = '0;
        unique case (rsel)
            RSEL_PEND: rd_d.rdata = DATA_W'(pend);
            RSEL_MASK: rd_d.rdata = DATA_W'(mask);
            RSEL_BASE: rd_d.rdata = DATA_W'(pool_base_o);
            RSEL_SIZE: rd_d.rdata = DATA_W'(pool_size_o);
            default:   rd_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rdata_o = rd_q.rdata;

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i && !reg_we_i && (reg_addr_i == OFS_EN_CLR)) |=> (reg_rdata_o == DATA_W'($past(mask))));
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i && !reg_we_i && (rsel == RSEL_NONE)) |=> (reg_rdata_o == '0));
endmodule

// File: tb/gfx_irq_ctrl_tb_top.sv
module gfx_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [4:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        frame_done_i = 1'b0;
    logic        flush_done_i = 1'b0;
    logic        bin_oom_i = 1'b0;
    logic        irq_o;
    logic [31:0] pool_base_o;
    logic [31:0] pool_size_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gfx_irq_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_sel_i    (reg_sel_i),
        .reg_we_i     (reg_we_i),
        .reg_addr_i   (reg_addr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .frame_done_i (frame_done_i),
        .flush_done_i (flush_done_i),
        .bin_oom_i    (bin_oom_i),
        .irq_o        (irq_o),
        .pool_base_o  (pool_base_o),
        .pool_size_o  (pool_size_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // monitor: compare read data one cycle after each read request
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R6: actual 0x%08h expected none (empty scoreboard)", reg_rdata_o);
            end else begin
                check(reg_rdata_o, exp_q.pop_front(), tag_q.pop_front());
            end
        end
        rd_seen = reg_sel_i && !reg_we_i;
    end

    task automatic finish_op();
        @(posedge clk); #1;
        reg_sel_i = 1'b0; reg_we_i = 1'b0;
        frame_done_i = 1'b0; flush_done_i = 1'b0; bin_oom_i = 1'b0;
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        reg_sel_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        finish_op();
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
        reg_sel_i = 1'b1; reg_we_i = 1'b0; reg_addr_i = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        finish_op();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check({31'b0, irq_o}, 32'h0, "R1 irq");
        check(pool_base_o, 32'h0, "R1 base out");
        check(pool_size_o, 32'h0, "R1 size out");
        check(reg_rdata_o, 32'h0, "R1 rdata");
        bus_read(5'h00, 32'h0, "R1 pend");
        bus_read(5'h04, 32'h0, "R1 mask");
        bus_read(5'h10, 32'h0, "R1 size");

        // R2 frame done latched, not enabled
        frame_done_i = 1'b1; finish_op();
        idle(2);
        bus_read(5'h00, 32'h1, "R2 frame bit");
        check({31'b0, irq_o}, 32'h0, "R7 masked stays low");

        // R4/R6 enable set and readback on both offsets
        bus_write(5'h04, 32'hFFFF_FFF9);  // bit0 only among [2:0]
        bus_read(5'h04, 32'h1, "R4 set bit0");
        bus_read(5'h08, 32'h1, "R6 clr offset reads mask");
        idle(1);
        check({31'b0, irq_o}, 32'h1, "R7 irq high");
        bus_write(5'h04, 32'h2);
        bus_read(5'h04, 32'h3, "R4 zero bits ignored");

        // R2/R3 flush latched, partial acknowledge
        flush_done_i = 1'b1; finish_op();
        idle(2);
        bus_read(5'h00, 32'h3, "R2 flush bit");
        bus_write(5'h00, 32'h2);
        bus_read(5'h00, 32'h1, "R3 partial ack");

        // R5 enable clear, zero bits ignored
        bus_write(5'h08, 32'h1);
        bus_read(5'h08, 32'h2, "R5 clear bit0 keep bit1");
        idle(2);
        check({31'b0, irq_o}, 32'h0, "R7 irq low after mask");
        bus_write(5'h00, 32'h1);
        bus_read(5'h00, 32'h0, "R3 full ack");

        // R10 event collides with acknowledge
        flush_done_i = 1'b1;
        bus_write(5'h00, 32'h2);
        bus_read(5'h00, 32'h2, "R10 event wins");
        bus_write(5'h00, 32'h2);
        bus_read(5'h00, 32'h0, "R3 ack after collision");

        // R8 out of memory level
        bus_write(5'h04, 32'h4);
        bin_oom_i = 1'b1; finish_op();
        idle(2);
        bus_read(5'h00, 32'h4, "R8 oom bit");
        check({31'b0, irq_o}, 32'h1, "R7 oom irq");
        bus_write(5'h00, 32'h4);
        bus_read(5'h00, 32'h4, "R8 ack ignored while condition");

        // R9 pool programming ends the condition
        bus_write(5'h0C, 32'h1000_0000);
        bus_write(5'h10, 32'h0004_0000);
        bus_read(5'h0C, 32'h1000_0000, "R9 base read");
        bus_read(5'h10, 32'h0004_0000, "R9 size read");
        check(pool_base_o, 32'h1000_0000, "R9 base out");
        check(pool_size_o, 32'h0004_0000, "R9 size out");
        bus_write(5'h00, 32'h4);
        bus_read(5'h00, 32'h0, "R9 ack after pool");
        idle(2);
        check({31'b0, irq_o}, 32'h0, "R7 irq drops");

        // R11 unmapped offset
        bus_write(5'h14, 32'hFFFF_FFFF);
        bus_read(5'h14, 32'h0, "R11 unmapped read");
        bus_read(5'h04, 32'h6, "R11 mask untouched");
        bus_read(5'h0C, 32'h1000_0000, "R11 base untouched");
        bus_read(5'h00, 32'h0, "R11 pend untouched");

        idle(3);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R6: actual %0d reads pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule